// File: doc/BRIEF.md
# Exception Entry State Controller

This block performs the register side effects a CPU core needs at the moment it takes an exception or an interrupt. On a one-cycle start strobe it samples the current program counter, status word, stack register (general register 15), vector base and faulting address. It then stores the return context in three shadow registers, and records the cause in one of two event-code registers. It also produces the status word and program counter the core must continue with.

The interrupt code wins when it is nonzero, and the exception code is then discarded. Otherwise the exception code is recorded together with the faulting virtual address. A trap instruction saves a return address one instruction past itself, so that returning from the handler resumes after the trap. When an entry is requested while the block bit of the status word is already set, the request is refused. The block then pulses a double-fault output and leaves every register untouched.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an accepted entry, saved_pc_o takes pc_i (except as in R6), saved_sr_o takes sr_i and saved_gr_o takes r15_i; all three are visible in the cycle after the start strobe.
- R2: When int_code_i is nonzero, int_event_o takes int_code_i, while exc_event_o and fault_vaddr_o keep their values and no trap adjustment is made, whatever exc_code_i holds.
- R3: When int_code_i is zero, exc_event_o takes exc_code_i, fault_vaddr_o takes fault_addr_i, and int_event_o keeps its value.
- R4: new_sr_o becomes sr_i with bits 30 (privileged mode), 29 (register bank) and 28 (block) set, all other bits copied.
- R5: new_pc_o becomes vbase_i + 0x100, modulo 2^32.
- R6: When int_code_i is zero and exc_code_i equals 0x160 (trap), saved_pc_o takes pc_i + 2, modulo 2^32.
- R7: A start strobe with sr_i bit 28 set gives a one-cycle dbl_fault_o pulse in the next cycle, no done_o pulse, and leaves every register output unchanged.
- R8: done_o is a one-cycle pulse in the cycle after an accepted start strobe; with start_i low no register output changes.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle entry request |
| exc_code_i | input | 12 | Exception cause code |
| int_code_i | input | 12 | Interrupt cause code, zero when no interrupt |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| r15_i | input | 32 | Current general register 15 |
| vbase_i | input | 32 | Vector base address |
| fault_addr_i | input | 32 | Faulting virtual address |
| saved_pc_o | output | 32 | Saved program counter |
| saved_sr_o | output | 32 | Saved status word |
| saved_gr_o | output | 32 | Saved general register 15 |
| exc_event_o | output | 12 | Exception event code register |
| int_event_o | output | 12 | Interrupt event code register |
| fault_vaddr_o | output | 32 | Recorded faulting address |
| new_sr_o | output | 32 | Status word to continue with |
| new_pc_o | output | 32 | Handler entry address |
| done_o | output | 1 | Entry completed pulse |
| dbl_fault_o | output | 1 | Entry refused, block bit already set |

## Verification
The bench sends an interrupt whose exception field holds the trap code. A design that let the exception field leak through would overwrite the exception register, move the fault address, or add 2 to the saved PC. A trap at PC 0xFFFFFFFE and a vector base near the top of memory check that both sums wrap rather than saturate. An entry with the block bit set checks that the design refuses it with no register change and no done pulse. An entry whose status word already has the mode bits set checks that the bits are OR-ed in and never toggled.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int MD_BIT = 30;
  localparam int RB_BIT = 29;
  localparam int BL_BIT = 28;
  localparam int N_SET  = 3;
  localparam int SET_BITS [N_SET] = '{MD_BIT, RB_BIT, BL_BIT};

  typedef enum logic [1:0] {
    EV_EXC  = 2'd0,
    EV_TRAP = 2'd1,
    EV_INT  = 2'd2
  } ev_kind_e;
endpackage

// File: rtl/exc_kind_dec.sv
module exc_kind_dec
  import exc_entry_pkg::*;
#(
  parameter int          EVW       = 12,
  parameter logic [11:0] TRAP_CODE = 12'h160
) (
  input  logic [EVW-1:0] exc_code_i,
  input  logic [EVW-1:0] int_code_i,
  input  logic           bl_i,
  output ev_kind_e       kind_o,
  output logic           blocked_o
);
  always_comb begin
    if (|int_code_i)                         kind_o = EV_INT;
    else if (exc_code_i == EVW'(TRAP_CODE)) kind_o = EV_TRAP;
    else                                     kind_o = EV_EXC;
  end
  assign blocked_o = bl_i;
endmodule

// File: rtl/exc_ctx_save.sv
module exc_ctx_save #(
  parameter int XW   = 32,
  parameter int STEP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          trap_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] sr_i,
  input  logic [XW-1:0] gr_i,
  output logic [XW-1:0] spc_o,
  output logic [XW-1:0] ssr_o,
  output logic [XW-1:0] sgr_o
);
  logic [XW-1:0] ret_pc;
  assign ret_pc = trap_i ? pc_i + XW'(STEP) : pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spc_o <= '0;
      ssr_o <= '0;
      sgr_o <= '0;
    end else if (load_i) begin
      spc_o <= ret_pc;
      ssr_o <= sr_i;
      sgr_o <= gr_i;
    end
  end

  // R1
  ctx_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ssr_o == $past(sr_i)) && (sgr_o == $past(gr_i)));
  // R6
  trap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && trap_i) |=> spc_o == $past(pc_i) + XW'(STEP));
endmodule

// File: rtl/exc_event_regs.sv
module exc_event_regs #(
  parameter int EVW = 12,
  parameter int XW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           is_int_i,
  input  logic [EVW-1:0] exc_code_i,
  input  logic [EVW-1:0] int_code_i,
  input  logic [XW-1:0]  fault_i,
  output logic [EVW-1:0] exc_ev_o,
  output logic [EVW-1:0] int_ev_o,
  output logic [XW-1:0]  fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_ev_o <= '0;
      int_ev_o <= '0;
      fault_o  <= '0;
    end else if (load_i) begin
      if (is_int_i) begin
        int_ev_o <= int_code_i;
      end else begin
        exc_ev_o <= exc_code_i;
        fault_o  <= fault_i;
      end
    end
  end

  // R2
  int_keeps_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && is_int_i) |=> $stable(exc_ev_o) && $stable(fault_o));
  // R3
  exc_keeps_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !is_int_i) |=> $stable(int_ev_o));
endmodule

// File: rtl/exc_target_regs.sv
module exc_target_regs
  import exc_entry_pkg::*;
#(
  parameter int          XW      = 32,
  parameter logic [31:0] VEC_OFS = 32'h100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [XW-1:0] sr_i,
  input  logic [XW-1:0] vbase_i,
  output logic [XW-1:0] new_sr_o,
  output logic [XW-1:0] new_pc_o
);
  logic [N_SET-1:0][XW-1:0] bit_mask;
  logic [XW-1:0]            set_mask;

  for (genvar g = 0; g < N_SET; g++) begin : g_mask
    assign bit_mask[g] = XW'(1) << SET_BITS[g];
  end

  always_comb begin
    set_mask = '0;
    for (int k = 0; k < N_SET; k++) set_mask = set_mask | bit_mask[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_sr_o <= '0;
      new_pc_o <= '0;
    end else if (load_i) begin
      new_sr_o <= sr_i | set_mask;
      new_pc_o <= vbase_i + XW'(VEC_OFS);
    end
  end

  // R4
  sr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> new_sr_o[MD_BIT] && new_sr_o[RB_BIT] && new_sr_o[BL_BIT]
               && (new_sr_o[27:0] == $past(sr_i[27:0])) && (new_sr_o[31] == $past(sr_i[31])));
  // R5
  vec_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> new_pc_o == $past(vbase_i) + XW'(VEC_OFS));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int          XW        = 32,
  parameter int          EVW       = 12,
  parameter int          STEP      = 2,
  parameter logic [31:0] VEC_OFS   = 32'h100,
  parameter logic [11:0] TRAP_CODE = 12'h160
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [EVW-1:0] exc_code_i,
  input  logic [EVW-1:0] int_code_i,
  input  logic [XW-1:0]  pc_i,
  input  logic [XW-1:0]  sr_i,
  input  logic [XW-1:0]  r15_i,
  input  logic [XW-1:0]  vbase_i,
  input  logic [XW-1:0]  fault_addr_i,
  output logic [XW-1:0]  saved_pc_o,
  output logic [XW-1:0]  saved_sr_o,
  output logic [XW-1:0]  saved_gr_o,
  output logic [EVW-1:0] exc_event_o,
  output logic [EVW-1:0] int_event_o,
  output logic [XW-1:0]  fault_vaddr_o,
  output logic [XW-1:0]  new_sr_o,
  output logic [XW-1:0]  new_pc_o,
  output logic           done_o,
  output logic           dbl_fault_o
);
  ev_kind_e kind;
  logic     blocked;
  logic     accept;

  exc_kind_dec #(.EVW(EVW), .TRAP_CODE(TRAP_CODE)) u_dec (
    .exc_code_i (exc_code_i),
    .int_code_i (int_code_i),
    .bl_i       (sr_i[BL_BIT]),
    .kind_o     (kind),
    .blocked_o  (blocked)
  );

  assign accept = start_i && !blocked;

  exc_ctx_save #(.XW(XW), .STEP(STEP)) u_ctx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .trap_i (kind == EV_TRAP),
    .pc_i   (pc_i),
    .sr_i   (sr_i),
    .gr_i   (r15_i),
    .spc_o  (saved_pc_o),
    .ssr_o  (saved_sr_o),
    .sgr_o  (saved_gr_o)
  );

  exc_event_regs #(.EVW(EVW), .XW(XW)) u_ev (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .is_int_i   (kind == EV_INT),
    .exc_code_i (exc_code_i),
    .int_code_i (int_code_i),
    .fault_i    (fault_addr_i),
    .exc_ev_o   (exc_event_o),
    .int_ev_o   (int_event_o),
    .fault_o    (fault_vaddr_o)
  );

  exc_target_regs #(.XW(XW), .VEC_OFS(VEC_OFS)) u_tgt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .sr_i     (sr_i),
    .vbase_i  (vbase_i),
    .new_sr_o (new_sr_o),
    .new_pc_o (new_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      dbl_fault_o <= 1'b0;
    end else begin
      done_o      <= accept;
      dbl_fault_o <= start_i && blocked;
    end
  end

  // R7
  dbl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && dbl_fault_o));
  // R7
  dbl_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_fault_o |-> $stable(saved_pc_o) && $stable(saved_sr_o) && $stable(new_pc_o)
                    && $stable(exc_event_o) && $stable(int_event_o));
  // R8
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i) && !$past(sr_i[BL_BIT]));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(saved_pc_o) && $stable(new_sr_o) && $stable(fault_vaddr_o));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] exc_code_i = '0, int_code_i = '0;
  logic [31:0] pc_i = '0, sr_i = '0, r15_i = '0, vbase_i = '0, fault_addr_i = '0;
  logic [31:0] saved_pc_o, saved_sr_o, saved_gr_o, fault_vaddr_o, new_sr_o, new_pc_o;
  logic [11:0] exc_event_o, int_event_o;
  logic        done_o, dbl_fault_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  exc_entry_ctrl dut (.*);

  // stimulus table: exception, interrupt with trap code ignored, trap,
  // blocked entry, trap with wrapping PC and base, mode bits already set
  localparam logic [31:0] V_PC   [NV] = '{32'h8C00_1000, 32'h8C00_2000, 32'h8C00_3002,
                                          32'h1234_5678, 32'hFFFF_FFFE, 32'h8C00_4444};
  localparam logic [31:0] V_SR   [NV] = '{32'h0000_00F0, 32'h8000_0001, 32'h0000_0300,
                                          32'h1000_0000, 32'h0000_0000, 32'h6000_0003};
  localparam logic [31:0] V_R15  [NV] = '{32'h8CFF_FF00, 32'h8CFF_FE00, 32'hAAAA_5555,
                                          32'hDEAD_BEEF, 32'h0000_0001, 32'h5A5A_A5A5};
  localparam logic [31:0] V_VB   [NV] = '{32'h8C00_0000, 32'hA000_0000, 32'h8C00_0000,
                                          32'h9000_0000, 32'hFFFF_FF80, 32'h0000_0000};
  localparam logic [11:0] V_EXC  [NV] = '{12'h0E0, 12'h160, 12'h160, 12'h180, 12'h160, 12'h1A0};
  localparam logic [11:0] V_INT  [NV] = '{12'h000, 12'h200, 12'h000, 12'h000, 12'h000, 12'h000};
  localparam logic [31:0] V_FLT  [NV] = '{32'h0040_0ABC, 32'hFFFF_0000, 32'h0000_1111,
                                          32'h7777_7777, 32'h0BAD_F00D, 32'h0000_2222};

  logic [31:0] m_spc, m_ssr, m_sgr, m_flt, m_nsr, m_npc;
  logic [11:0] m_exc, m_int;

  task automatic chk32(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk32("R1", {tag, " saved_pc"}, saved_pc_o, m_spc);
    chk32("R1", {tag, " saved_sr"}, saved_sr_o, m_ssr);
    chk32("R1", {tag, " saved_gr"}, saved_gr_o, m_sgr);
    chk32("R3", {tag, " exc_event"}, {20'd0, exc_event_o}, {20'd0, m_exc});
    chk32("R2", {tag, " int_event"}, {20'd0, int_event_o}, {20'd0, m_int});
    chk32("R3", {tag, " fault_vaddr"}, fault_vaddr_o, m_flt);
    chk32("R4", {tag, " new_sr"}, new_sr_o, m_nsr);
    chk32("R5", {tag, " new_pc"}, new_pc_o, m_npc);
  endtask

  task automatic run_vec(input int i);
    bit blk;
    blk = V_SR[i][28];
    @(negedge clk_i);
    pc_i = V_PC[i]; sr_i = V_SR[i]; r15_i = V_R15[i]; vbase_i = V_VB[i];
    exc_code_i = V_EXC[i]; int_code_i = V_INT[i]; fault_addr_i = V_FLT[i];
    start_i = 1'b1;
    if (!blk) begin
      m_spc = (V_INT[i] == 0 && V_EXC[i] == 12'h160) ? V_PC[i] + 32'd2 : V_PC[i];
      m_ssr = V_SR[i];
      m_sgr = V_R15[i];
      if (V_INT[i] != 0) m_int = V_INT[i];
      else begin
        m_exc = V_EXC[i];
        m_flt = V_FLT[i];
      end
      m_nsr = V_SR[i] | 32'h7000_0000;
      m_npc = V_VB[i] + 32'h100;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    chk32("R8", $sformatf("v%0d done", i), {31'd0, done_o}, {31'd0, !blk});
    chk32("R7", $sformatf("v%0d dbl_fault", i), {31'd0, dbl_fault_o}, {31'd0, blk});
    chk_all($sformatf("v%0d", i));
    @(negedge clk_i);
    chk32("R8", $sformatf("v%0d done one cycle", i), {31'd0, done_o}, 32'd0);
    chk32("R7", $sformatf("v%0d dbl one cycle", i), {31'd0, dbl_fault_o}, 32'd0);
  endtask

  initial begin
    m_spc = '0; m_ssr = '0; m_sgr = '0; m_flt = '0; m_nsr = '0; m_npc = '0;
    m_exc = '0; m_int = '0;
    repeat (2) @(negedge clk_i);
    // R9 reset state
    chk_all("reset");
    chk32("R9", "reset done", {31'd0, done_o}, 32'd0);
    chk32("R9", "reset dbl", {31'd0, dbl_fault_o}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(i);

    // R8 idle inputs change without start: nothing moves
    @(negedge clk_i);
    pc_i = 32'h1111_1111; sr_i = 32'h0; exc_code_i = 12'h0E0; int_code_i = 12'h0;
    fault_addr_i = 32'h9999_9999; vbase_i = 32'h4000_0000;
    repeat (3) @(negedge clk_i);
    chk_all("R8 idle");

    // R7 block bit set with an interrupt pending: refused, registers frozen
    @(negedge clk_i);
    sr_i = 32'hF000_0000; int_code_i = 12'h3C0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk32("R7", "blocked int dbl", {31'd0, dbl_fault_o}, 32'd1);
    chk32("R7", "blocked int done", {31'd0, done_o}, 32'd0);
    chk_all("R7 blocked int");

    // R2 back-to-back: interrupt right after an exception
    @(negedge clk_i);
    sr_i = 32'h0; pc_i = 32'h0000_0100; int_code_i = 12'h000; exc_code_i = 12'h040;
    fault_addr_i = 32'h0000_0ABC; r15_i = 32'h33; vbase_i = 32'h10; start_i = 1'b1;
    m_spc = 32'h100; m_ssr = 32'h0; m_sgr = 32'h33; m_exc = 12'h040; m_flt = 32'hABC;
    m_nsr = 32'h7000_0000; m_npc = 32'h110;
    @(negedge clk_i);
    chk_all("R3 b2b first");
    int_code_i = 12'h240; exc_code_i = 12'h160; pc_i = 32'h0000_0200; fault_addr_i = 32'h5;
    m_spc = 32'h200; m_int = 12'h240;
    @(negedge clk_i);
    start_i = 1'b0;
    chk32("R8", "b2b second done", {31'd0, done_o}, 32'd1);
    chk_all("R2 b2b second");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule